// File: doc/BRIEF.md
# I2S Transmit Serializer (Clock and Frame Master)

This block turns a stream of 32-bit sample words into a standard I2S output and drives all three I2S lines itself. It derives the bit clock from the block clock, which serves as the master clock, using an 8-bit divider setting. It generates word select and shifts each sample out most significant bit first. Each frame carries a left word and then a right word. Only the low-order bits of each word are sent, up to the configured sample width, so one slot spans that many bit clocks.

Sample words come from an external show-ahead FIFO. The FIFO presents its head word together with an empty flag, and the block pulses a pop strobe in the cycle it takes the word. Starting transmission always emits one silent frame first. A frame that starts with no data queued is sent as silence. Clearing the enable lets the current frame finish before the lines go quiet. The divider setting, sample width and enable are expected to come from a configuration register outside this block.

Top module: `i2s_tx_serializer`

## Requirements
- R1: The bit clock stays high for `ratio`+2 block-clock cycles and low for `ratio`+2 cycles, giving a period of 2*(`ratio`+2). It runs continuously once reset is released, whether transmission is enabled or not.
- R2: A slot is W bit clocks long. W equals `resolution` when that value is between 1 and 32. W is 32 when `resolution` is 0 or above 32. Only bits W-1..0 of each FIFO word are transmitted, and the upper bits are discarded.
- R3: Word select is 0 for the left slot and 1 for the right slot. It changes one bit clock before the first bit of the new slot. Bits go out most significant first. Word select and serial data change only together with a falling edge of the bit clock.
- R4: When transmission starts from idle, the first frame is all zeros, left slot first, and nothing is popped during it.
- R5: At each frame start while enabled, a non-empty FIFO is popped for the left word. At the start of that frame's right slot, the FIFO is popped again for the right word if it is not empty.
- R6: If the FIFO is empty at a frame start, both slots of that frame are zeros and no pop occurs anywhere in that frame, even if data arrives during the left slot.
- R7: After the enable is cleared, the frame in progress completes. From the next frame boundary onward, word select stays 0, serial data stays 0 and no pop is issued.
- R8: The pop strobe is a single block-clock pulse in the cycle the bit clock falls. It is never issued while the FIFO reports empty.
- R9: During reset the bit clock, word select, serial data and the pop strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the master clock for bit-clock derivation |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmission enable |
| ratio | input | 8 | Divider setting; bit-clock half period is ratio+2 cycles |
| resolution | input | 6 | Sample width in bits (0 or above 32 means 32) |
| fifoData | input | 32 | Head word of the show-ahead FIFO |
| fifoEmpty | input | 1 | FIFO holds no word |
| fifoPop | output | 1 | Consume the head word this cycle |
| bitClk | output | 1 | I2S bit clock |
| wordSel | output | 1 | I2S word select, 0 = left, 1 = right |
| serialData | output | 1 | I2S serial data |

## Verification
The bench decodes the I2S lines the way a receiver does, sampling on rising bit-clock edges. It checks every decoded word, its channel and its slot length against the sequence implied by the FIFO contents. A design that forgot the leading silent frame would show queued data in the first two decoded words. A design that aligned the word wrongly or applied no mask would decode upper bits at 8 and 16 bits, and a design that ignored the width clamp would produce short slots when `resolution` is 0. The bench also makes data arrive during the left slot of a frame that started empty. A design that pops at the right boundary regardless would send a right word on its own and shift the stereo pairing. A bench-side monitor catches any change of word select or data off a falling edge, and any repeated pop or pop while empty. After the enable is cleared, the bench counts pops and watches the lines, so a block that stopped mid-frame or kept consuming words is reported.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } txState_t;

  // Strobes from control to datapath, all qualified by fallTick.
  typedef struct packed {
    logic fallTick;   // bit clock falls at the end of this cycle
    logic loadEn;     // slot boundary: reload the shift register
    logic loadFifo;   // reload from the FIFO word (else zeros)
    logic wsNext;     // word select value for the coming bit period
  } txStrobe_t;

endpackage

// File: rtl/i2s_tx_clkdiv.sv
module i2s_tx_clkdiv #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratio,
  output logic               bitClk,
  output logic               fallTick
);
  localparam int CNT_W = RATIO_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfLast;
  logic             wrap;

  // Half period spans ratio+2 cycles: counter runs 0..ratio+1.
  assign halfLast = {1'b0, ratio} + CNT_W'(1);
  assign wrap     = (cnt >= halfLast);
  assign fallTick = wrap & bitClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      bitClk <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      bitClk <= ~bitClk;
    end else begin
      cnt    <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RES_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fallTick,
  input  logic             txEnable,
  input  logic [RES_W-1:0] resolution,
  input  logic             fifoEmpty,
  output logic             fifoPop,
  output txStrobe_t        strobe
);
  localparam logic [RES_W-1:0] LAST_MAX = RES_W'(WORD_W - 1);

  txState_t         state, nState;
  logic [RES_W-1:0] bitPos, nPos, lastPos;
  logic             chan, nChan;
  logic             frameLive, nLive;
  logic             loadEn, loadFifo;
  logic             slotEnd;

  // Last bit index of a slot, with out-of-range widths clamped to a full word.
  always_comb begin
    if (resolution == '0 || resolution > RES_W'(WORD_W)) lastPos = LAST_MAX;
    else                                                 lastPos = resolution - RES_W'(1);
  end

  assign slotEnd = (bitPos >= lastPos);

  always_comb begin
    nState   = state;
    nPos     = bitPos;
    nChan    = chan;
    nLive    = frameLive;
    loadEn   = 1'b0;
    loadFifo = 1'b0;
    case (state)
      ST_IDLE: begin
        if (txEnable) begin
          // Start with a silent frame, left slot first.
          nState = ST_ACTIVE;
          nPos   = '0;
          nChan  = 1'b0;
          nLive  = 1'b0;
          loadEn = 1'b1;
        end
      end
      default: begin
        if (slotEnd) begin
          nPos   = '0;
          loadEn = 1'b1;
          if (chan) begin
            // Frame boundary.
            nChan = 1'b0;
            if (!txEnable) begin
              nState = ST_IDLE;
              nLive  = 1'b0;
            end else if (!fifoEmpty) begin
              loadFifo = 1'b1;
              nLive    = 1'b1;
            end else begin
              nLive    = 1'b0;
            end
          end else begin
            // Left-to-right boundary inside a frame.
            nChan = 1'b1;
            if (frameLive && !fifoEmpty) loadFifo = 1'b1;
          end
        end else begin
          nPos = bitPos + RES_W'(1);
        end
      end
    endcase
  end

  assign fifoPop = fallTick & loadFifo;
  assign strobe  = '{fallTick: fallTick, loadEn: loadEn, loadFifo: loadFifo, wsNext: nChan};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitPos    <= '0;
      chan      <= 1'b0;
      frameLive <= 1'b0;
    end else if (fallTick) begin
      state     <= nState;
      bitPos    <= nPos;
      chan      <= nChan;
      frameLive <= nLive;
    end
  end

  // R8: never consume from an empty FIFO
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty);

  // R8: pop is a single-cycle pulse
  p_pop_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> !fifoPop);

  // R7: an idle serializer consumes nothing
  p_idle_no_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !fifoPop);

endmodule

// File: rtl/i2s_tx_datapath.sv
module i2s_tx_datapath
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RES_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [WORD_W-1:0] fifoData,
  input  logic [RES_W-1:0]  resolution,
  input  logic              bitClk,
  output logic              serialData,
  output logic              wordSel
);
  localparam int AMT_W = RES_W + 1;

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] aligned;
  logic [AMT_W-1:0]  effRes;
  logic [AMT_W-1:0]  shiftAmt;

  // Move the low effRes bits of the word to the top so the MSB leaves first.
  always_comb begin
    if (resolution == '0 || {1'b0, resolution} > AMT_W'(WORD_W)) effRes = AMT_W'(WORD_W);
    else                                                          effRes = {1'b0, resolution};
    shiftAmt = AMT_W'(WORD_W) - effRes;
    aligned  = fifoData << shiftAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      serialData <= 1'b0;
      wordSel    <= 1'b0;
    end else if (strobe.fallTick) begin
      serialData <= shiftReg[WORD_W-1];
      wordSel    <= strobe.wsNext;
      if (strobe.loadEn) shiftReg <= strobe.loadFifo ? aligned : '0;
      else               shiftReg <= shiftReg << 1;
    end
  end

  // R3: word select moves only with a falling bit clock
  p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordSel) |-> $fell(bitClk));

  // R3: data moves only with a falling bit clock
  p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serialData) |-> $fell(bitClk));

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RATIO_W = 8,
  parameter int RES_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEnable,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [RES_W-1:0]   resolution,
  input  logic [WORD_W-1:0]  fifoData,
  input  logic               fifoEmpty,
  output logic               fifoPop,
  output logic               bitClk,
  output logic               wordSel,
  output logic               serialData
);
  logic      fallTick;
  txStrobe_t strobe;

  i2s_tx_clkdiv #(.RATIO_W(RATIO_W)) u_clkdiv (
    .clk      (clk),
    .rstN     (rstN),
    .ratio    (ratio),
    .bitClk   (bitClk),
    .fallTick (fallTick)
  );

  i2s_tx_ctrl #(.WORD_W(WORD_W), .RES_W(RES_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fallTick   (fallTick),
    .txEnable   (txEnable),
    .resolution (resolution),
    .fifoEmpty  (fifoEmpty),
    .fifoPop    (fifoPop),
    .strobe     (strobe)
  );

  i2s_tx_datapath #(.WORD_W(WORD_W), .RES_W(RES_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fifoData   (fifoData),
    .resolution (resolution),
    .bitClk     (bitClk),
    .serialData (serialData),
    .wordSel    (wordSel)
  );

endmodule

// File: tb/i2s_tx_serializer_bench.sv
module i2s_tx_serializer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        txEnable = 1'b0;
  logic [7:0]  ratio = 8'd0;
  logic [5:0]  resolution = 6'd32;
  logic [31:0] fifoData;
  logic        fifoEmpty;
  logic        fifoPop, bitClk, wordSel, serialData;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  // Show-ahead FIFO model
  logic [31:0] fifoMem [64];
  logic [5:0]  rdPtr, wrPtr;
  int          popCount;
  assign fifoEmpty = (rdPtr == wrPtr);
  assign fifoData  = fifoMem[rdPtr];

  // Receiver model state
  logic [31:0] rxWords [64];
  logic        rxChan  [64];
  int          rxBits  [64];
  int          rxCount;
  int          curRes = 32;
  logic [31:0] acc;
  int          bitsSeen;
  logic        prevB, prevWs, prevWsS, prevSdS, prevPop;
  int          edgeViol, popViol;

  i2s_tx_serializer u_i2s_tx_serializer (
    .clk, .rstN, .txEnable, .ratio, .resolution, .fifoData, .fifoEmpty,
    .fifoPop, .bitClk, .wordSel, .serialData
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      popCount <= 0;
    end else if (fifoPop) begin
      rdPtr    <= rdPtr + 6'd1;
      popCount <= popCount + 1;
    end
  end

  function automatic logic [31:0] resMask(input int r);
    if (r == 0 || r >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << r) - 32'd1;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      rxCount = 0; acc = '0; bitsSeen = 0;
      prevB = 1'b0; prevWs = 1'b0; prevWsS = 1'b0; prevSdS = 1'b0; prevPop = 1'b0;
      edgeViol = 0; popViol = 0;
    end else begin
      if (bitClk && !prevB) begin
        acc = {acc[30:0], serialData};
        bitsSeen++;
        if (wordSel != prevWs) begin
          if (rxCount < 64) begin
            rxWords[rxCount] = acc & resMask(curRes);
            rxChan[rxCount]  = prevWs;
            rxBits[rxCount]  = bitsSeen;
          end
          rxCount++;
          acc = '0;
          bitsSeen = 0;
        end
        prevWs = wordSel;
      end
      if ((wordSel !== prevWsS || serialData !== prevSdS) && !(prevB && !bitClk)) edgeViol++;
      if (fifoPop && (prevPop || fifoEmpty)) popViol++;
      prevB = bitClk; prevWsS = wordSel; prevSdS = serialData; prevPop = fifoPop;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [7:0] r, input logic [5:0] res);
    @(negedge clk);
    rstN = 1'b0; txEnable = 1'b0; ratio = r; resolution = res;
    curRes = int'(res); wrPtr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic push(input logic [31:0] w);
    fifoMem[wrPtr] = w;
    wrPtr = wrPtr + 6'd1;
  endtask

  task automatic waitRx(input int n);
    while (rxCount < n) @(negedge clk);
  endtask

  task automatic checkWord(input string tag, input int idx, input logic [31:0] w, input logic ch);
    check({tag, " word"}, rxWords[idx], w);
    check({tag, " chan"}, {31'd0, rxChan[idx]}, {31'd0, ch});
  endtask

  task automatic checkMonitors(input string tag);
    check({tag, " R3 edges off falling bit clock"}, edgeViol, 0);
    check({tag, " R8 pop pulse rules"}, popViol, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 bitClk", {31'd0, bitClk}, 0);
    check("R9 wordSel", {31'd0, wordSel}, 0);
    check("R9 serialData", {31'd0, serialData}, 0);
    check("R9 fifoPop", {31'd0, fifoPop}, 0);
  endtask

  task automatic testDivider(input logic [7:0] r);
    int hi, lo;
    doReset(r, 6'd32);
    while (bitClk !== 1'b0) @(negedge clk);
    while (bitClk !== 1'b1) @(negedge clk);
    hi = 0;
    do begin @(negedge clk); hi++; end while (bitClk == 1'b1);
    lo = 0;
    do begin @(negedge clk); lo++; end while (bitClk == 1'b0);
    check($sformatf("R1 high half ratio %0d", r), hi, int'(r) + 2);
    check($sformatf("R1 low half ratio %0d", r), lo, int'(r) + 2);
  endtask

  task automatic testBasic();
    doReset(8'd0, 6'd32);
    push(32'hA5A5_0F0F); push(32'h1234_5678); push(32'hDEAD_BEEF); push(32'h8000_0001);
    @(negedge clk); txEnable = 1'b1;
    waitRx(6);
    checkWord("R4 silent left", 0, 32'h0, 1'b0);
    checkWord("R4 silent right", 1, 32'h0, 1'b1);
    checkWord("R5 frame1 left", 2, 32'hA5A5_0F0F, 1'b0);
    checkWord("R5 frame1 right", 3, 32'h1234_5678, 1'b1);
    checkWord("R5 frame2 left", 4, 32'hDEAD_BEEF, 1'b0);
    checkWord("R5 frame2 right", 5, 32'h8000_0001, 1'b1);
    check("R2 slot length 32", rxBits[3], 32);
    check("R5 pop count", popCount, 4);
    checkMonitors("basic");
  endtask

  task automatic testRes16();
    doReset(8'd2, 6'd16);
    push(32'hABCD_1234); push(32'hFFFF_8001);
    @(negedge clk); txEnable = 1'b1;
    waitRx(4);
    checkWord("R2 16-bit left masked", 2, 32'h0000_1234, 1'b0);
    checkWord("R2 16-bit right masked", 3, 32'h0000_8001, 1'b1);
    check("R2 slot length 16", rxBits[2], 16);
    checkMonitors("res16");
  endtask

  task automatic testClamp();
    doReset(8'd0, 6'd0);
    push(32'h8000_0001); push(32'hC000_0003);
    @(negedge clk); txEnable = 1'b1;
    waitRx(4);
    checkWord("R2 width 0 clamps left", 2, 32'h8000_0001, 1'b0);
    checkWord("R2 width 0 clamps right", 3, 32'hC000_0003, 1'b1);
    check("R2 clamped slot length", rxBits[3], 32);
  endtask

  task automatic testEmpty();
    doReset(8'd0, 6'd8);
    @(negedge clk); txEnable = 1'b1;
    waitRx(4);
    checkWord("R6 empty frame left", 2, 32'h0, 1'b0);
    checkWord("R6 empty frame right", 3, 32'h0, 1'b1);
    check("R6 no pops while empty", popCount, 0);
    // Frame 3 already started empty; data now arrives in its left slot.
    push(32'h1234_56C3); push(32'h0000_005A);
    waitRx(6);
    check("R6 no right pop in empty frame", popCount, 1);
    checkWord("R6 late data left", 4, 32'h0, 1'b0);
    checkWord("R6 late data right", 5, 32'h0, 1'b1);
    waitRx(8);
    checkWord("R2 8-bit masked left", 6, 32'h0000_00C3, 1'b0);
    checkWord("R5 next frame right", 7, 32'h0000_005A, 1'b1);
    check("R2 slot length 8", rxBits[6], 8);
    checkMonitors("empty");
  endtask

  task automatic testStop();
    int bad;
    doReset(8'd0, 6'd8);
    for (int i = 0; i < 6; i++) push(32'h11 * (i + 1));
    @(negedge clk); txEnable = 1'b1;
    waitRx(4);
    txEnable = 1'b0;
    waitRx(6);
    checkWord("R7 frame finishes left", 4, 32'h33, 1'b0);
    checkWord("R7 frame finishes right", 5, 32'h44, 1'b1);
    repeat (4) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wordSel !== 1'b0 || serialData !== 1'b0) bad++;
    end
    check("R7 lines quiet after stop", bad, 0);
    check("R7 no further words", rxCount, 6);
    check("R7 no further pops", popCount, 4);
    checkMonitors("stop");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      failCount++;
      checkCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    testReset();
    testDivider(8'd0);
    testDivider(8'd2);
    testDivider(8'd7);
    testBasic();
    testRes16();
    testClamp();
    testEmpty();
    testStop();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

endmodule